// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block keeps a small bank of CAN transmit mailboxes. Each mailbox holds a frame: an identifier with an extended-format flag, a length code, a remote-frame flag and eight data bytes. Each mailbox also has a priority and a mode bit. Software loads mailboxes through a single register write port. A write to a mailbox's control field with the transfer-command bit set makes it pending. The arbiter then offers the most urgent pending frame to a bit-level transmit engine over a valid/ready handshake. The engine ends every accepted frame with either a done pulse or a lost-arbitration pulse.

Pending requests can be cancelled with one masked abort write. Each mailbox reports a ready bit and an abort bit through a read port. Every completion or cancellation raises the interrupt flag whose index equals the mailbox number. Reading the flags clears them.

The arbiter offers frames freely before acceptance, so a newly pending, more urgent mailbox can replace the one on offer. Once the engine takes a frame, that mailbox owns the engine until the engine ends the frame.

Top module: `can_tx_mb_arbiter`

## Requirements
- R1: After reset, every mailbox is disabled. Every mailbox reads ready=1 (status bit 23) and abort=0 (status bit 22). All interrupt flags are 0 and `txValid` is low.
- R2: Among pending mailboxes, the one with the smallest priority value is offered on the transmit port. Priority 0 is the most urgent.
- R3: When several pending mailboxes share the smallest priority value, the one with the lowest mailbox number is offered.
- R4: A write to field 4 (control) with bit 23 set makes an enabled, non-pending mailbox pending. In the same write, bits 19:16 give the length code and bit 20 gives the remote flag. The offered frame carries these values, together with the identifier (field 1, bits 28:0, extended flag bit 29) and the data (field 2 = bytes 0-3, field 3 = bytes 4-7). While the request is outstanding, the ready bit reads 0.
- R5: A done pulse for the accepted frame sets that mailbox's ready bit to 1 and its abort bit to 0, and sets its interrupt flag.
- R6: A write to field 5 (abort) cancels every pending mailbox named in data bits NUM_MB-1:0 that the engine does not hold. Each cancelled mailbox reads ready=1 and abort=1 and raises its interrupt flag. Mailboxes not named in the mask keep their state.
- R7: Field 0 (mode) holds the enable bit in bit 0 and the priority in bits 7:4. Priority writes and identifier writes take effect only while the mailbox is disabled. A transfer command to a disabled mailbox is ignored.
- R8: The offered mailbox is latched when `txValid` and `txReady` are both high. While the engine holds it, `txValid` stays low and no other mailbox can take its place.
- R9: A lost-arbitration pulse frees the engine and leaves the mailbox pending, so it is arbitrated again against the other pending mailboxes.
- R10: An abort aimed at the mailbox held by the engine is deferred. A following done completes the mailbox normally (abort=0). A following lost-arbitration cancels it (ready=1, abort=1).
- R11: A pulse on `irqRdEn` clears all interrupt flags. A flag set in the same cycle survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrMb | input | IDX_W | Target mailbox of the write |
| regWrField | input | 3 | Field select: 0 mode, 1 id, 2 data low, 3 data high, 4 control, 5 abort |
| regWrData | input | 32 | Write data |
| rdMb | input | IDX_W | Mailbox whose status is shown on rdStatus |
| rdStatus | output | 32 | Bit 23 ready, bit 22 abort, bit 0 enabled |
| irqRdEn | input | 1 | Interrupt status read strobe (clears flags) |
| irqStatus | output | NUM_MB | Per-mailbox event flags |
| txValid | output | 1 | A frame is offered to the engine |
| txReady | input | 1 | Engine accepts the offered frame |
| txId | output | ID_W | Identifier of the offered frame |
| txExt | output | 1 | Extended-format flag |
| txDlc | output | 4 | Length code |
| txRtr | output | 1 | Remote-frame flag |
| txData | output | 64 | Data bytes, byte 0 in bits 7:0 |
| txDone | input | 1 | Engine finished the held frame |
| txLost | input | 1 | Engine lost arbitration on the held frame |

## Verification
The bench builds the block with four mailboxes, 4-bit priorities and 29-bit identifiers. With only four mailboxes, every non-empty set of pending mailboxes can be swept under several computed priority patterns. The patterns contain both strict orderings and ties, so the winner rule and the masked abort are checked for every subset. Directed sequences then cover the handshake corners: pre-emption attempts during a held frame, lost arbitration, deferred aborts ending either way, and a flag clear that coincides with a new event.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

  localparam logic [2:0] FLD_MODE  = 3'd0;
  localparam logic [2:0] FLD_ID    = 3'd1;
  localparam logic [2:0] FLD_DLO   = 3'd2;
  localparam logic [2:0] FLD_DHI   = 3'd3;
  localparam logic [2:0] FLD_CTRL  = 3'd4;
  localparam logic [2:0] FLD_ABORT = 3'd5;

  localparam int CMD_BIT   = 23;
  localparam int RTR_BIT   = 20;
  localparam int DLC_LSB   = 16;
  localparam int EXT_BIT   = 29;
  localparam int PRIO_LSB  = 4;
  localparam int ST_READY  = 23;
  localparam int ST_ABORT  = 22;

  typedef struct packed {
    logic loadPrio;
    logic loadId;
    logic loadDlo;
    logic loadDhi;
    logic loadCtrl;
  } mbStrobe_t;

endpackage

// File: rtl/tx_mb_ctrl.sv
module tx_mb_ctrl
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [IDX_W-1:0]               regWrMb,
  input  logic [2:0]                     regWrField,
  input  logic [31:0]                    regWrData,
  input  logic [NUM_MB-1:0][PRIO_W-1:0]  prioVec,
  input  logic                           txReady,
  input  logic                           txDone,
  input  logic                           txLost,
  input  logic                           irqRdEn,
  input  logic [IDX_W-1:0]               rdMb,
  output mbStrobe_t                      strobe,
  output logic                           txValid,
  output logic [IDX_W-1:0]               txIdx,
  output logic                           busy,
  output logic [IDX_W-1:0]               busyIdx,
  output logic [NUM_MB-1:0]              pendingVec,
  output logic [NUM_MB-1:0]              readyVec,
  output logic [NUM_MB-1:0]              irqStatus,
  output logic [31:0]                    rdStatus
);

  logic [NUM_MB-1:0] modeVec;
  logic [NUM_MB-1:0] abortVec;
  logic              busyQ;
  logic [IDX_W-1:0]  busyIdxQ;
  logic [IDX_W-1:0]  candIdx;
  logic              found;
  logic [PRIO_W-1:0] bestPrio;
  logic              ctrlGo;
  logic              abortWr;
  logic              accept;
  logic              finDone;
  logic              finLost;

  // register write decode: gating of id/prio by mode, request acceptance
  always_comb begin
    ctrlGo = regWrEn && (regWrField == FLD_CTRL) && regWrData[CMD_BIT]
             && modeVec[regWrMb] && !pendingVec[regWrMb];
    strobe.loadPrio = regWrEn && (regWrField == FLD_MODE) && !modeVec[regWrMb];
    strobe.loadId   = regWrEn && (regWrField == FLD_ID) && !modeVec[regWrMb];
    strobe.loadDlo  = regWrEn && (regWrField == FLD_DLO);
    strobe.loadDhi  = regWrEn && (regWrField == FLD_DHI);
    strobe.loadCtrl = ctrlGo;
    abortWr = regWrEn && (regWrField == FLD_ABORT);
  end

  // arbiter: smallest priority wins, strict compare keeps lowest index on ties
  always_comb begin
    found    = 1'b0;
    candIdx  = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM_MB; i++) begin
      if (pendingVec[i] && (!found || prioVec[i] < bestPrio)) begin
        found    = 1'b1;
        candIdx  = IDX_W'(i);
        bestPrio = prioVec[i];
      end
    end
  end

  assign txValid = found && !busyQ;
  assign accept  = txValid && txReady;
  assign finDone = busyQ && txDone;
  assign finLost = busyQ && txLost && !txDone;
  assign txIdx   = busyQ ? busyIdxQ : candIdx;
  assign busy    = busyQ;
  assign busyIdx = busyIdxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      busyIdxQ <= '0;
    end else if (accept) begin
      busyQ    <= 1'b1;
      busyIdxQ <= candIdx;
    end else if (finDone || finLost) begin
      busyQ    <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_MB; i++) begin : gMb
    logic modeR, pendR, readyR, abortR, abortReqR, irqR;
    logic hitI, ownI, abHit, startI, doneI, lostI, cancelI, lostAbI, deferI, evtI;

    always_comb begin
      hitI    = (regWrMb == IDX_W'(i));
      ownI    = busyQ && (busyIdxQ == IDX_W'(i));
      abHit   = abortWr && regWrData[i];
      startI  = ctrlGo && hitI;
      doneI   = finDone && ownI;
      lostI   = finLost && ownI;
      cancelI = abHit && pendR && !ownI;
      lostAbI = lostI && (abortReqR || abHit);
      deferI  = abHit && ownI && !doneI && !lostI;
      evtI    = doneI || cancelI || lostAbI;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeR     <= 1'b0;
        pendR     <= 1'b0;
        readyR    <= 1'b1;
        abortR    <= 1'b0;
        abortReqR <= 1'b0;
        irqR      <= 1'b0;
      end else begin
        if (regWrEn && hitI && (regWrField == FLD_MODE))
          modeR <= regWrData[0];
        if (startI) begin
          pendR     <= 1'b1;
          readyR    <= 1'b0;
          abortR    <= 1'b0;
          abortReqR <= 1'b0;
        end else if (doneI) begin
          pendR     <= 1'b0;
          readyR    <= 1'b1;
          abortR    <= 1'b0;
          abortReqR <= 1'b0;
        end else if (cancelI || lostAbI) begin
          pendR     <= 1'b0;
          readyR    <= 1'b1;
          abortR    <= 1'b1;
          abortReqR <= 1'b0;
        end else if (deferI) begin
          abortReqR <= 1'b1;
        end
        irqR <= evtI || (irqR && !irqRdEn);
      end
    end

    assign modeVec[i]    = modeR;
    assign pendingVec[i] = pendR;
    assign readyVec[i]   = readyR;
    assign abortVec[i]   = abortR;
    assign irqStatus[i]  = irqR;
  end

  always_comb begin
    rdStatus           = '0;
    rdStatus[ST_READY] = readyVec[rdMb];
    rdStatus[ST_ABORT] = abortVec[rdMb];
    rdStatus[0]        = modeVec[rdMb];
  end

endmodule

// File: rtl/tx_mb_data.sv
module tx_mb_data
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int PRIO_W = 4,
  parameter int ID_W   = 29,
  parameter int IDX_W  = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mbStrobe_t                     strobe,
  input  logic [IDX_W-1:0]              wrMb,
  input  logic [31:0]                   wrData,
  input  logic [IDX_W-1:0]              txIdx,
  output logic [NUM_MB-1:0][PRIO_W-1:0] prioVec,
  output logic [ID_W-1:0]               txId,
  output logic                          txExt,
  output logic [3:0]                    txDlc,
  output logic                          txRtr,
  output logic [63:0]                   txData
);

  logic [ID_W-1:0] idA   [NUM_MB];
  logic            extA  [NUM_MB];
  logic [3:0]      dlcA  [NUM_MB];
  logic            rtrA  [NUM_MB];
  logic [63:0]     dataA [NUM_MB];

  for (genvar i = 0; i < NUM_MB; i++) begin : gStore
    logic              selI;
    logic [PRIO_W-1:0] prioR;
    logic [ID_W-1:0]   idR;
    logic              extR;
    logic [3:0]        dlcR;
    logic              rtrR;
    logic [63:0]       dataR;

    assign selI = (wrMb == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioR <= '0;
        idR   <= '0;
        extR  <= 1'b0;
        dlcR  <= '0;
        rtrR  <= 1'b0;
        dataR <= '0;
      end else if (selI) begin
        if (strobe.loadPrio) prioR <= wrData[PRIO_LSB +: PRIO_W];
        if (strobe.loadId) begin
          idR  <= wrData[ID_W-1:0];
          extR <= wrData[EXT_BIT];
        end
        if (strobe.loadDlo) dataR[31:0]  <= wrData;
        if (strobe.loadDhi) dataR[63:32] <= wrData;
        if (strobe.loadCtrl) begin
          dlcR <= wrData[DLC_LSB +: 4];
          rtrR <= wrData[RTR_BIT];
        end
      end
    end

    assign prioVec[i] = prioR;
    assign idA[i]     = idR;
    assign extA[i]    = extR;
    assign dlcA[i]    = dlcR;
    assign rtrA[i]    = rtrR;
    assign dataA[i]   = dataR;
  end

  assign txId   = idA[txIdx];
  assign txExt  = extA[txIdx];
  assign txDlc  = dlcA[txIdx];
  assign txRtr  = rtrA[txIdx];
  assign txData = dataA[txIdx];

endmodule

// File: rtl/can_tx_mb_arbiter.sv
module can_tx_mb_arbiter
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int PRIO_W = 4,
  parameter int ID_W   = 29,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regWrMb,
  input  logic [2:0]        regWrField,
  input  logic [31:0]       regWrData,
  input  logic [IDX_W-1:0]  rdMb,
  output logic [31:0]       rdStatus,
  input  logic              irqRdEn,
  output logic [NUM_MB-1:0] irqStatus,
  output logic              txValid,
  input  logic              txReady,
  output logic [ID_W-1:0]   txId,
  output logic              txExt,
  output logic [3:0]        txDlc,
  output logic              txRtr,
  output logic [63:0]       txData,
  input  logic              txDone,
  input  logic              txLost
);

  mbStrobe_t                     strobe;
  logic [NUM_MB-1:0][PRIO_W-1:0] prioVec;
  logic [IDX_W-1:0]              txIdx;
  logic                          busy;
  logic [IDX_W-1:0]              busyIdx;
  logic [NUM_MB-1:0]             pendingVec;
  logic [NUM_MB-1:0]             readyVec;

  tx_mb_ctrl #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrMb(regWrMb), .regWrField(regWrField), .regWrData(regWrData),
    .prioVec(prioVec), .txReady(txReady), .txDone(txDone), .txLost(txLost),
    .irqRdEn(irqRdEn), .rdMb(rdMb), .strobe(strobe),
    .txValid(txValid), .txIdx(txIdx), .busy(busy), .busyIdx(busyIdx),
    .pendingVec(pendingVec), .readyVec(readyVec), .irqStatus(irqStatus),
    .rdStatus(rdStatus)
  );

  tx_mb_data #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W), .ID_W(ID_W), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrMb(regWrMb), .wrData(regWrData),
    .txIdx(txIdx), .prioVec(prioVec), .txId(txId), .txExt(txExt),
    .txDlc(txDlc), .txRtr(txRtr), .txData(txData)
  );

endmodule

// File: rtl/can_tx_mb_checker.sv
module can_tx_mb_checker #(
  parameter int NUM_MB = 4,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              txValid,
  input logic              txReady,
  input logic              txDone,
  input logic              txLost,
  input logic [IDX_W-1:0]  txIdx,
  input logic              busy,
  input logic [IDX_W-1:0]  busyIdx,
  input logic [NUM_MB-1:0] pendingVec,
  input logic [NUM_MB-1:0] readyVec,
  input logic [NUM_MB-1:0] irqStatus
);

  assert_ready_excl_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pendingVec & readyVec) == '0);

  assert_offer_is_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> pendingVec[txIdx]);

  assert_no_offer_while_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !txValid);

  assert_accept_latches_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (busy && busyIdx == $past(txIdx)));

  assert_hold_winner_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !txDone && !txLost) |=> (busy && busyIdx == $past(busyIdx)));

  assert_done_reports_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txDone) |=> (irqStatus[$past(busyIdx)] && readyVec[$past(busyIdx)]));

  assert_lost_frees_engine_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txLost && !txDone) |=> !busy);

  assert_irq_rise_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((irqStatus & ~$past(irqStatus)) & ~readyVec) == '0);

endmodule

bind can_tx_mb_arbiter can_tx_mb_checker #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady), .txDone(txDone),
  .txLost(txLost), .txIdx(txIdx), .busy(busy), .busyIdx(busyIdx),
  .pendingVec(pendingVec), .readyVec(readyVec), .irqStatus(irqStatus)
);

// File: tb/tb_can_tx_mb_arbiter.sv
module tb_can_tx_mb_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_MB = 4;
  localparam int PRIO_W = 4;
  localparam int ID_W   = 29;
  localparam int IDX_W  = 2;
  localparam logic [31:0] CMD = 32'h0080_0000;

  logic              clk = 1'b0;
  logic              rstN;
  logic              regWrEn;
  logic [IDX_W-1:0]  regWrMb;
  logic [2:0]        regWrField;
  logic [31:0]       regWrData;
  logic [IDX_W-1:0]  rdMb;
  logic [31:0]       rdStatus;
  logic              irqRdEn;
  logic [NUM_MB-1:0] irqStatus;
  logic              txValid, txReady, txExt, txRtr, txDone, txLost;
  logic [ID_W-1:0]   txId;
  logic [3:0]        txDlc;
  logic [63:0]       txData;

  int errors = 0;
  int checks = 0;

  can_tx_mb_arbiter #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W), .ID_W(ID_W)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrMb(regWrMb),
    .regWrField(regWrField), .regWrData(regWrData), .rdMb(rdMb), .rdStatus(rdStatus),
    .irqRdEn(irqRdEn), .irqStatus(irqStatus), .txValid(txValid), .txReady(txReady),
    .txId(txId), .txExt(txExt), .txDlc(txDlc), .txRtr(txRtr), .txData(txData),
    .txDone(txDone), .txLost(txLost)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int mb, int fld, logic [31:0] d);
    regWrEn = 1'b1; regWrMb = IDX_W'(mb); regWrField = 3'(fld); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic accept();
    txReady = 1'b1; @(negedge clk); txReady = 1'b0;
  endtask

  task automatic done();
    txDone = 1'b1; @(negedge clk); txDone = 1'b0;
  endtask

  task automatic lost();
    txLost = 1'b1; @(negedge clk); txLost = 1'b0;
  endtask

  task automatic irqRead();
    irqRdEn = 1'b1; @(negedge clk); irqRdEn = 1'b0;
  endtask

  task automatic stat(int mb, output logic rdy, output logic ab);
    rdMb = IDX_W'(mb); #1;
    rdy = rdStatus[23]; ab = rdStatus[22];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic rdy, ab;
    rstN = 1'b0; regWrEn = 1'b0; regWrMb = '0; regWrField = '0; regWrData = '0;
    rdMb = '0; irqRdEn = 1'b0; txReady = 1'b0; txDone = 1'b0; txLost = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    #1;
    check("R1 irq", 64'(irqStatus), 0);
    check("R1 txValid", 64'(txValid), 0);
    for (int m = 0; m < NUM_MB; m++) begin
      rdMb = IDX_W'(m); #1;
      check("R1 status", 64'(rdStatus), 64'h0080_0000);
    end

    // load frames; priority 3, enabled
    for (int m = 0; m < NUM_MB; m++) begin
      wr(m, 1, 32'h100 + m);
      wr(m, 2, 32'hA000_0000 + m);
      wr(m, 3, 32'hB000_0000 + m);
      wr(m, 0, 32'h31);
    end

    // sweep: all pending subsets under computed priority patterns
    for (int seed = 0; seed < 4; seed++) begin
      for (int sub = 1; sub < 16; sub++) begin
        int p[NUM_MB];
        int w, best, ties;
        for (int m = 0; m < NUM_MB; m++) begin
          p[m] = (seed * (m + 1) + (m >> 1)) % 4;
          wr(m, 0, 32'(p[m] << 4));
          wr(m, 0, 32'((p[m] << 4) | 1));
        end
        for (int m = 0; m < NUM_MB; m++)
          if (sub[m]) wr(m, 4, CMD | 32'(m << 16));
        best = 99; w = 0; ties = 0;
        for (int m = 0; m < NUM_MB; m++)
          if (sub[m] && p[m] < best) begin best = p[m]; w = m; end
        for (int m = 0; m < NUM_MB; m++)
          if (sub[m] && p[m] == best) ties++;
        #1;
        if (ties > 1) check("R3 tie winner id", 64'(txId), 64'(32'h100 + w));
        else          check("R2 priority winner id", 64'(txId), 64'(32'h100 + w));
        check("R4 winner length code", 64'(txDlc), 64'(w));
        wr(0, 5, 32'hF);
        #1;
        check("R6 abort all raises flags", 64'(irqStatus), 64'(sub));
        irqRead();
      end
    end

    // R7: id/prio ignored while enabled; command ignored while disabled
    for (int m = 0; m < NUM_MB; m++) begin
      wr(m, 0, 32'h30); wr(m, 0, 32'h31);
    end
    wr(1, 1, 32'h555);
    wr(1, 0, 32'h01);
    wr(0, 4, CMD); wr(1, 4, CMD);
    #1 check("R7 prio write ignored when enabled", 64'(txId), 64'h100);
    wr(0, 5, 32'h1);
    #1 check("R7 id write ignored when enabled", 64'(txId), 64'h101);
    wr(1, 5, 32'h2);
    irqRead();
    wr(3, 0, 32'h30);
    wr(3, 4, CMD);
    stat(3, rdy, ab);
    check("R7 disabled request ignored ready", 64'(rdy), 1);
    check("R7 disabled request no offer", 64'(txValid), 0);

    // R4 frame fields
    wr(2, 4, CMD | 32'h0010_0000 | 32'h0005_0000);
    #1;
    check("R4 dlc", 64'(txDlc), 5);
    check("R4 rtr", 64'(txRtr), 1);
    check("R4 data", txData, 64'hB000_0002_A000_0002);
    check("R4 id", 64'(txId), 64'h102);
    stat(2, rdy, ab);
    check("R4 ready low while pending", 64'(rdy), 0);

    // R8 latch, no pre-emption
    accept();
    #1 check("R8 no offer while held", 64'(txValid), 0);
    wr(0, 4, CMD);
    #1 check("R8 urgent arrival cannot pre-empt", 64'(txValid), 0);

    // R9 lost arbitration
    lost();
    #1;
    check("R9 re-offer after lost", 64'(txValid), 1);
    check("R9 rearbitrated winner", 64'(txId), 64'h100);
    stat(2, rdy, ab);
    check("R9 lost mailbox still pending", 64'(rdy), 0);

    // R5 completion
    accept(); done();
    #1;
    check("R5 irq flag", 64'(irqStatus), 64'b0001);
    stat(0, rdy, ab);
    check("R5 ready", 64'(rdy), 1);
    check("R5 abort clear", 64'(ab), 0);
    check("R5 next offer", 64'(txId), 64'h102);

    // R10 deferred abort, done path
    accept();
    wr(0, 5, 32'h4);
    stat(2, rdy, ab);
    check("R10 held mailbox not cancelled", 64'(rdy), 0);
    done();
    stat(2, rdy, ab);
    check("R10 done wins ready", 64'(rdy), 1);
    check("R10 done wins abort", 64'(ab), 0);
    // R10 deferred abort, lost path
    wr(1, 4, CMD);
    #1 check("R10 offer mb1", 64'(txId), 64'h101);
    accept();
    wr(0, 5, 32'h2);
    lost();
    stat(1, rdy, ab);
    check("R10 lost cancels ready", 64'(rdy), 1);
    check("R10 lost cancels abort", 64'(ab), 1);
    check("R10 nothing offered", 64'(txValid), 0);

    // R11 clear on read, concurrent set survives
    #1 check("R11 flags before read", 64'(irqStatus), 64'b0111);
    irqRead();
    #1 check("R11 cleared", 64'(irqStatus), 0);
    wr(3, 0, 32'h31);
    wr(3, 4, CMD);
    accept();
    wr(0, 4, CMD);
    wr(0, 5, 32'h1);
    #1 check("R11 flag from cancel", 64'(irqStatus), 64'b0001);
    txDone = 1'b1; irqRdEn = 1'b1;
    @(negedge clk);
    txDone = 1'b0; irqRdEn = 1'b0;
    #1 check("R11 same-cycle set survives", 64'(irqStatus), 64'b1000);
    irqRead();

    // R6 partial mask
    wr(0, 4, CMD); wr(1, 4, CMD); wr(3, 4, CMD);
    wr(0, 5, 32'h3);
    #1 check("R6 listed flags", 64'(irqStatus), 64'b0011);
    stat(0, rdy, ab);
    check("R6 cancelled abort bit", 64'(ab), 1);
    stat(3, rdy, ab);
    check("R6 unlisted still pending", 64'(rdy), 0);
    check("R6 unlisted offered", 64'(txId), 64'h103);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule